// File: doc/BRIEF.md
# Protection and Fault Mode Sequencer

This block decides when a quasi-resonant power controller may drive its switch. It receives already-digitized protection flags (supply thresholds, supply overvoltage, line brown-out, thermal shutdown, dim enable, the result of a current-sense impedance test, a per-cycle "current sense above stop level" flag, auxiliary winding short and an externally set overvoltage). From these it steps through seven operating modes and produces a gate enable, a low-power off indication and a request to run the current-sense impedance test.

Every fault has its own recovery path. Some faults lead to a timed auto-recovery wait. The external overvoltage input leads to its own wait, whose length depends on the variant. In the latching variant, supply overvoltage and the secondary over-current event hold the block latched until one of three clearing events occurs. All long timers count clock cycles and are parameters, so a short simulation can use small values. The mode is visible on a 3-bit code output: 0 reset, 1 off, 2 fault check, 3 run, 4 auto-recovery wait, 5 overvoltage wait, 6 latched.

Top module: `fault_sequencer`

## Requirements
- R1: After synchronous reset the mode code is 0 and all three control outputs are low. The mode moves to 1 (off) at the first clock edge that samples `vcc_above_on` high.
- R2: In off, the mode stays 1 while `dim_en` is low. It moves to 2 (fault check) at the edge that samples both `vcc_above_on` and `dim_en` high. In mode 2, `cs_meas_req` is high and `gate_en` is low.
- R3: In mode 2, an edge that samples `cs_test_done` high moves the mode to 4 if `cs_short` is high, and to 3 (run) if it is low.
- R4: In run, `dim_en` low, `cs_short`, `aux_short`, `vcc_ovp` or a secondary over-current event moves the mode to 4. When LATCHING is 1, `vcc_ovp` and the over-current event move it to 6 instead.
- R5: The secondary over-current event is declared after STOP_CYCLES edges in run that sample both `cycle_end` and `cs_over_stop` high. The mode changes at the next edge. The count restarts at every entry to run.
- R6: Mode 4 lasts exactly AR_CYCLES cycles and then moves to 1.
- R7: `adj_ovp` in run moves the mode to 5. Mode 5 lasts OVP_WAIT_A cycles when LATCHING is 1, or OVP_WAIT_B cycles when it is 0, and then moves to 2.
- R8: Mode 6 moves to 1 only on `vcc_below_off`, a rising edge of `bo_nok`, or a long dim-off. Thermal shutdown and all other faults leave it at 6.
- R9: From modes 2, 3, 4 and 5, `vcc_below_off`, a rising edge of `bo_nok`, `therm_sd` or a long dim-off moves the mode to 1.
- R10: A long dim-off is seen at the DIM_OFF_CYCLES-th consecutive edge that samples `dim_en` low.
- R11: `gate_en` is high only in mode 3, and `off_mode` is high only in mode 1.
- R12: When faults arrive together, the order of priority is: supply below off, then brown-out/thermal/long dim-off, then the latching faults, then `adj_ovp`, then the auto-recovery faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vcc_above_on | input | 1 | Supply above start threshold |
| vcc_below_off | input | 1 | Supply below stop threshold |
| vcc_ovp | input | 1 | Supply overvoltage |
| bo_nok | input | 1 | Line brown-out present |
| therm_sd | input | 1 | Thermal shutdown |
| dim_en | input | 1 | Dim input above enable level |
| cs_test_done | input | 1 | Impedance test result valid strobe |
| cs_short | input | 1 | Current-sense short found |
| cycle_end | input | 1 | End of a switching cycle strobe |
| cs_over_stop | input | 1 | Current sense exceeded stop level this cycle |
| aux_short | input | 1 | Auxiliary winding / output short |
| adj_ovp | input | 1 | External overvoltage trip |
| gate_en | output | 1 | Switch pulses allowed |
| off_mode | output | 1 | Low-power off mode |
| cs_meas_req | output | 1 | Run current-sense impedance test |
| state_o | output | 3 | Mode code |

## Verification
The embedded assertions check, on every cycle, several local rules: the exit from reset, the failed impedance test leading to auto-recovery, a supply drop forcing off from any active mode, off holding while dim is low, the gate only opening out of a passed test, and the over-current event only following a qualifying cycle. The durations of the waits, the difference between variants, latch clearing and simultaneous-fault priority need multi-cycle histories. Only the bench scenarios show these, with a reference model of both variants running alongside directed and random stimulus.

// File: rtl/fs_pkg.sv
// Shared types for the fault sequencer.
// Assumes: mode codes are observable on the top-level port, so values are fixed.
package fs_pkg;
    typedef enum logic [2:0] {
        FS_RESET  = 3'd0,
        FS_OFF    = 3'd1,
        FS_CHECK  = 3'd2,
        FS_RUN    = 3'd3,
        FS_ARWAIT = 3'd4,
        FS_OVWAIT = 3'd5,
        FS_LATCH  = 3'd6
    } fs_state_e;
endpackage

// File: rtl/fs_cycle_timer.sv
// Saturating cycle timer: counts while en is high and clears when en is low.
// done is high while en is high and the count has reached limit-1.
// Assumes: limit >= 1 and limit <= MAXV.
module fs_cycle_timer #(
    parameter int MAXV = 16,
    parameter int W    = $clog2(MAXV + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt;
    logic         at_end;

    assign at_end = (cnt == limit - 1'b1);
    assign done   = en && at_end;

    // Count cycles of en, holding at limit-1.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (!en)    cnt <= '0;
        else if (!at_end) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/fs_stop_counter.sv
// Counts switching cycles in which current sense passed the stop level.
// It declares the over-current event once CYCLES such cycles have been seen.
// Assumes: en is high only in the run mode; leaving run clears the count.
module fs_stop_counter #(
    parameter int CYCLES = 4,
    parameter int W      = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic cycle_end,
    input  logic over_stop,
    output logic event_o
);
    logic [W-1:0] count;

    assign event_o = (count == W'(CYCLES));

    // Accumulate qualifying cycles; saturate at CYCLES.
    always_ff @(posedge clk) begin
        if (!rst_n)  count <= '0;
        else if (!en) count <= '0;
        else if (cycle_end && over_stop && !event_o) count <= count + 1'b1;
    end

    AST_STOP_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(event_o) |-> $past(en && cycle_end && over_stop)); // R5
endmodule

// File: rtl/fs_mode_ctrl.sv
// Mode register and next-mode decision with fixed fault priority.
// Assumes: wait_done and dim_long come from timers cleared outside this module.
module fs_mode_ctrl
    import fs_pkg::*;
#(
    parameter bit LATCHING = 1'b1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      vcc_above_on,
    input  logic      vcc_below_off,
    input  logic      vcc_ovp,
    input  logic      bo_rise,
    input  logic      therm_sd,
    input  logic      dim_en,
    input  logic      dim_long,
    input  logic      cs_test_done,
    input  logic      cs_short,
    input  logic      aux_short,
    input  logic      adj_ovp,
    input  logic      stop_event,
    input  logic      wait_done,
    output fs_state_e state
);
    fs_state_e nxt;
    logic      go_off;
    logic      latch_clear;
    logic      latch_fault;
    logic      ar_fault;

    assign go_off      = vcc_below_off || bo_rise || therm_sd || dim_long;
    assign latch_clear = vcc_below_off || bo_rise || dim_long;
    assign latch_fault = LATCHING && (vcc_ovp || stop_event);
    assign ar_fault    = !dim_en || cs_short || vcc_ovp || aux_short || stop_event;

    // Next-mode selection, highest priority first.
    always_comb begin
        nxt = state;
        unique case (state)
            FS_RESET:  if (vcc_above_on) nxt = FS_OFF;
            FS_OFF:    if (vcc_above_on && dim_en) nxt = FS_CHECK;
            FS_CHECK: begin
                if (go_off)            nxt = FS_OFF;
                else if (cs_test_done) nxt = cs_short ? FS_ARWAIT : FS_RUN;
            end
            FS_RUN: begin
                if (go_off)           nxt = FS_OFF;
                else if (latch_fault) nxt = FS_LATCH;
                else if (adj_ovp)     nxt = FS_OVWAIT;
                else if (ar_fault)    nxt = FS_ARWAIT;
            end
            FS_ARWAIT: if (go_off || wait_done) nxt = FS_OFF;
            FS_OVWAIT: begin
                if (go_off)         nxt = FS_OFF;
                else if (wait_done) nxt = FS_CHECK;
            end
            FS_LATCH:  if (latch_clear) nxt = FS_OFF;
            default:   nxt = FS_RESET;
        endcase
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= FS_RESET;
        else        state <= nxt;
    end

    AST_RESET_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_RESET) && vcc_above_on |=> (state == FS_OFF)); // R1
    AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_OFF) && !dim_en |=> (state == FS_OFF)); // R2
    AST_CHECK_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_CHECK) && cs_test_done && cs_short && !vcc_below_off && !bo_rise
        && !therm_sd && !dim_long |=> (state == FS_ARWAIT)); // R3
    AST_RUN_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == FS_RUN) |-> $past(state == FS_CHECK && cs_test_done)); // R3
    AST_SUPPLY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {FS_CHECK, FS_RUN, FS_ARWAIT, FS_OVWAIT, FS_LATCH}) && vcc_below_off
        |=> (state == FS_OFF)); // R9
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_LATCH) && !vcc_below_off && !bo_rise && !dim_long
        |=> (state == FS_LATCH)); // R8
endmodule

// File: rtl/fault_sequencer.sv
// Top of the protection and fault mode sequencer.
// It joins the mode controller, the shared wait timer, the dim-off timer and the
// over-current cycle counter. All fault inputs are synchronous single-bit flags.
module fault_sequencer
    import fs_pkg::*;
#(
    parameter bit LATCHING       = 1'b1,
    parameter int AR_CYCLES      = 40_000_000,
    parameter int OVP_WAIT_A     = 40_000_000,
    parameter int OVP_WAIT_B     = 10_000_000,
    parameter int DIM_OFF_CYCLES = 40_000_000,
    parameter int STOP_CYCLES    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vcc_above_on,
    input  logic       vcc_below_off,
    input  logic       vcc_ovp,
    input  logic       bo_nok,
    input  logic       therm_sd,
    input  logic       dim_en,
    input  logic       cs_test_done,
    input  logic       cs_short,
    input  logic       cycle_end,
    input  logic       cs_over_stop,
    input  logic       aux_short,
    input  logic       adj_ovp,
    output logic       gate_en,
    output logic       off_mode,
    output logic       cs_meas_req,
    output logic [2:0] state_o
);
    localparam int OVP_WAIT = LATCHING ? OVP_WAIT_A : OVP_WAIT_B;
    localparam int WAIT_MAX = (AR_CYCLES > OVP_WAIT) ? AR_CYCLES : OVP_WAIT;
    localparam int WW       = $clog2(WAIT_MAX + 1);
    localparam int DW       = $clog2(DIM_OFF_CYCLES + 1);

    fs_state_e     state;
    logic          bo_prev;
    logic          bo_rise;
    logic          dim_long;
    logic          wait_en;
    logic          wait_done;
    logic [WW-1:0] wait_lim;
    logic          stop_event;

    // Remember the last brown-out flag for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) bo_prev <= 1'b0;
        else        bo_prev <= bo_nok;
    end

    assign bo_rise  = bo_nok && !bo_prev;
    assign wait_en  = (state == FS_ARWAIT) || (state == FS_OVWAIT);
    assign wait_lim = (state == FS_ARWAIT) ? WW'(AR_CYCLES) : WW'(OVP_WAIT);

    fs_cycle_timer #(.MAXV(WAIT_MAX), .W(WW)) u_wait_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (wait_en),
        .limit (wait_lim),
        .done  (wait_done)
    );

    fs_cycle_timer #(.MAXV(DIM_OFF_CYCLES), .W(DW)) u_dim_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (!dim_en),
        .limit (DW'(DIM_OFF_CYCLES)),
        .done  (dim_long)
    );

    fs_stop_counter #(.CYCLES(STOP_CYCLES)) u_stop_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (state == FS_RUN),
        .cycle_end (cycle_end),
        .over_stop (cs_over_stop),
        .event_o   (stop_event)
    );

    fs_mode_ctrl #(.LATCHING(LATCHING)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .vcc_above_on  (vcc_above_on),
        .vcc_below_off (vcc_below_off),
        .vcc_ovp       (vcc_ovp),
        .bo_rise       (bo_rise),
        .therm_sd      (therm_sd),
        .dim_en        (dim_en),
        .dim_long      (dim_long),
        .cs_test_done  (cs_test_done),
        .cs_short      (cs_short),
        .aux_short     (aux_short),
        .adj_ovp       (adj_ovp),
        .stop_event    (stop_event),
        .wait_done     (wait_done),
        .state         (state)
    );

    assign gate_en     = (state == FS_RUN);
    assign off_mode    = (state == FS_OFF);
    assign cs_meas_req = (state == FS_CHECK);
    assign state_o     = state;
endmodule

// File: tb/fault_sequencer_tb.sv
// Bench: two instances (latching and auto-recovery) share stimulus; a bench model
// of both variants is stepped every cycle, plus directed scenario checks.
module fault_sequencer_tb;
    localparam int AR  = 20;
    localparam int OVA = 16;
    localparam int OVB = 6;
    localparam int DIM = 12;
    localparam int OCP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vcc_above_on = 0, vcc_below_off = 0, vcc_ovp = 0, bo_nok = 0, therm_sd = 0;
    logic dim_en = 0, cs_test_done = 0, cs_short = 0, cycle_end = 0, cs_over_stop = 0;
    logic aux_short = 0, adj_ovp = 0;
    logic       gate_a, off_a, meas_a, gate_b, off_b, meas_b;
    logic [2:0] st_a, st_b;

    int n_chk = 0;
    int n_err = 0;
    int cyc_cnt = 0;
    bit done_flag = 0;

    int ms[2];
    int mw[2];
    int mo[2];
    int md;
    bit mbo;

    always #4 clk = ~clk;

    fault_sequencer #(.LATCHING(1'b1), .AR_CYCLES(AR), .OVP_WAIT_A(OVA), .OVP_WAIT_B(OVB),
        .DIM_OFF_CYCLES(DIM), .STOP_CYCLES(OCP)) u_dut (
        .clk(clk), .rst_n(rst_n), .vcc_above_on(vcc_above_on), .vcc_below_off(vcc_below_off),
        .vcc_ovp(vcc_ovp), .bo_nok(bo_nok), .therm_sd(therm_sd), .dim_en(dim_en),
        .cs_test_done(cs_test_done), .cs_short(cs_short), .cycle_end(cycle_end),
        .cs_over_stop(cs_over_stop), .aux_short(aux_short), .adj_ovp(adj_ovp),
        .gate_en(gate_a), .off_mode(off_a), .cs_meas_req(meas_a), .state_o(st_a));

    fault_sequencer #(.LATCHING(1'b0), .AR_CYCLES(AR), .OVP_WAIT_A(OVA), .OVP_WAIT_B(OVB),
        .DIM_OFF_CYCLES(DIM), .STOP_CYCLES(OCP)) u_dut_b (
        .clk(clk), .rst_n(rst_n), .vcc_above_on(vcc_above_on), .vcc_below_off(vcc_below_off),
        .vcc_ovp(vcc_ovp), .bo_nok(bo_nok), .therm_sd(therm_sd), .dim_en(dim_en),
        .cs_test_done(cs_test_done), .cs_short(cs_short), .cycle_end(cycle_end),
        .cs_over_stop(cs_over_stop), .aux_short(aux_short), .adj_ovp(adj_ovp),
        .gate_en(gate_b), .off_mode(off_b), .cs_meas_req(meas_b), .state_o(st_b));

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            if (n_err <= 30) $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Next mode from the requirements (R1..R4, R6..R9, R12).
    function automatic int nxt_mode(input int s, input bit lat, input bit dlong, input bit borise,
                                    input bit ocpev, input bit wdone);
        bit goff = vcc_below_off || borise || therm_sd || dlong;
        case (s)
            0: return vcc_above_on ? 1 : 0;
            1: return (vcc_above_on && dim_en) ? 2 : 1;
            2: if (goff) return 1; else if (cs_test_done) return cs_short ? 4 : 3; else return 2;
            3: begin
                if (goff) return 1;
                if (lat && (vcc_ovp || ocpev)) return 6;
                if (adj_ovp) return 5;
                if (!dim_en || cs_short || vcc_ovp || aux_short || ocpev) return 4;
                return 3;
            end
            4: return (goff || wdone) ? 1 : 4;
            5: if (goff) return 1; else if (wdone) return 2; else return 5;
            6: return (vcc_below_off || borise || dlong) ? 1 : 6;
            default: return 0;
        endcase
    endfunction

    // One clock: advance the model with current inputs, then compare at the negedge.
    task automatic cyc();
        bit dlong = !dim_en && (md == DIM - 1);
        bit borise = bo_nok && !mbo;
        int ns[2];
        int nw[2];
        int no[2];
        for (int v = 0; v < 2; v++) begin
            int lim = (ms[v] == 4) ? AR : ((v == 0) ? OVA : OVB);
            bit wen = (ms[v] == 4) || (ms[v] == 5);
            bit wdone = wen && (mw[v] == lim - 1);
            ns[v] = nxt_mode(ms[v], (v == 0), dlong, borise, (mo[v] == OCP), wdone);
            nw[v] = wen ? ((mw[v] < lim - 1) ? mw[v] + 1 : mw[v]) : 0;
            no[v] = (ms[v] == 3) ? ((cycle_end && cs_over_stop && mo[v] < OCP) ? mo[v] + 1 : mo[v]) : 0;
        end
        if (!rst_n) begin
            ns = '{0, 0}; nw = '{0, 0}; no = '{0, 0}; md = 0; mbo = 0;
        end else begin
            md = !dim_en ? ((md < DIM - 1) ? md + 1 : md) : 0;
            mbo = bo_nok;
        end
        ms = ns; mw = nw; mo = no;
        @(negedge clk);
        cyc_cnt++;
        chk("R12 model latching mode", st_a, ms[0]);
        chk("R12 model auto mode", st_b, ms[1]);
        chk("R11 gate only in run", gate_a, (ms[0] == 3));
        chk("R11 off only in off", off_b, (ms[1] == 1));
    endtask

    task automatic quiet();
        vcc_below_off = 0; vcc_ovp = 0; bo_nok = 0; therm_sd = 0; cs_test_done = 0;
        cs_short = 0; cycle_end = 0; cs_over_stop = 0; aux_short = 0; adj_ovp = 0;
        vcc_above_on = 1; dim_en = 1;
    endtask

    task automatic to_run();
        quiet(); cyc();
        cs_test_done = 1; cyc();
        cs_test_done = 0;
    endtask

    initial begin
        ms = '{0, 0}; mw = '{0, 0}; mo = '{0, 0}; md = 0; mbo = 0;
        repeat (3) cyc();
        chk("R1 reset mode", st_a, 0);
        chk("R1 reset gate", gate_a, 0);
        chk("R1 reset meas", meas_b, 0);
        chk("R1 reset off", off_a, 0);
        rst_n = 1;
        vcc_above_on = 1; dim_en = 0; cyc();
        chk("R1 leave reset", st_a, 1);
        chk("R11 off_mode in off", off_a, 1);
        repeat (3) cyc();
        chk("R2 off holds with dim low", st_b, 1);
        dim_en = 1; cyc();
        chk("R2 enter check", st_a, 2);
        chk("R2 meas request", meas_a, 1);
        chk("R2 gate low in check", gate_a, 0);
        cs_test_done = 1; cs_short = 1; cyc();
        chk("R3 failed test to wait", st_a, 4);
        cs_test_done = 0; cs_short = 0;
        repeat (AR - 1) cyc();
        chk("R6 still waiting", st_b, 4);
        cyc();
        chk("R6 wait ends in off", st_a, 1);
        to_run();
        chk("R3 pass to run", st_a, 3);
        chk("R11 gate in run", gate_b, 1);
        vcc_ovp = 1; cyc(); vcc_ovp = 0;
        chk("R4 supply ovp latching", st_a, 6);
        chk("R4 supply ovp auto", st_b, 4);
        therm_sd = 1; repeat (3) cyc(); therm_sd = 0;
        chk("R8 thermal ignored in latch", st_a, 6);
        chk("R9 thermal forces off", st_b, 1);
        bo_nok = 1; cyc(); bo_nok = 0;
        chk("R8 brown-out edge clears latch", st_a, 1);
        to_run();
        for (int k = 0; k < 3; k++) begin
            cycle_end = 1; cs_over_stop = 1; cyc();
            cycle_end = 0; cs_over_stop = 0; cyc();
        end
        chk("R5 three cycles not enough", st_a, 3);
        cycle_end = 1; cs_over_stop = 1; cyc();
        cycle_end = 0; cs_over_stop = 0;
        chk("R5 event one cycle later", st_a, 3);
        cyc();
        chk("R5 latching over-current", st_a, 6);
        chk("R5 auto over-current", st_b, 4);
        dim_en = 0;
        repeat (DIM - 1) cyc();
        chk("R10 dim short low keeps latch", st_a, 6);
        cyc();
        chk("R10 long dim-off clears latch", st_a, 1);
        chk("R9 long dim-off from wait", st_b, 1);
        to_run();
        adj_ovp = 1; cyc(); adj_ovp = 0;
        chk("R7 adj ovp wait", st_a, 5);
        repeat (OVB - 1) cyc();
        chk("R7 short wait running", st_b, 5);
        cyc();
        chk("R7 short wait to check", st_b, 2);
        chk("R7 long wait running", st_a, 5);
        repeat (OVA - OVB) cyc();
        chk("R7 long wait to check", st_a, 2);
        to_run();
        vcc_above_on = 0; vcc_below_off = 1; vcc_ovp = 1; adj_ovp = 1; cyc();
        chk("R12 below-off wins", st_a, 1);
        to_run();
        therm_sd = 1; vcc_ovp = 1; cyc();
        chk("R12 thermal over latch", st_a, 1);
        to_run();
        vcc_ovp = 1; adj_ovp = 1; cyc(); quiet();
        chk("R12 latch over adj", st_a, 6);
        chk("R12 adj over auto fault", st_b, 5);
        vcc_above_on = 0; vcc_below_off = 1; cyc(); quiet();
        chk("R8 supply drop clears latch", st_a, 1);
        chk("R9 supply drop from wait", st_b, 1);

        void'($urandom(32'd20250));
        quiet();
        for (int i = 0; i < 2500; i++) begin
            vcc_below_off = ($urandom % 400) == 0;
            vcc_above_on  = !vcc_below_off && (($urandom % 100) != 0);
            if (bo_nok) bo_nok = ($urandom % 5) != 0;
            else        bo_nok = ($urandom % 300) == 0;
            therm_sd = ($urandom % 500) == 0;
            if (($urandom % 60) == 0) dim_en = !dim_en;
            vcc_ovp = ($urandom % 300) == 0;
            cs_test_done = ($urandom % 4) == 0;
            cs_short = ($urandom % 10) == 0;
            cycle_end = ($urandom % 3) == 0;
            cs_over_stop = ($urandom % 3) == 0;
            aux_short = ($urandom % 400) == 0;
            adj_ovp = ($urandom % 300) == 0;
            cyc();
        end
        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc_cnt, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule